// File: doc/BRIEF.md
# 16-bit SEC-DED Error Detection and Correction Unit

This unit protects a 16-bit memory word with a 6-bit check word. Each check bit is the parity of a fixed group of eight data bits, and every data bit belongs to exactly three groups. Check bits 0 and 1 are kept inverted, so a stuck-low or stuck-high memory word cannot look clean. A 2-bit mode input selects one of four functions. The first computes the check word for a memory write. The second presents a read word. The third captures that word and shows the error flags. The fourth drives out the corrected data together with the 6-bit syndrome.

Separate input and output ports take the place of shared bidirectional pins. A controller runs a read in order: pass (`01`), latch (`11`), then correct (`10`). The word is captured when `mode[1]` goes from low to high. Everything shown in the latch and correct modes comes from that captured copy, so the memory bus may change afterwards without affecting the result.

Top module: `edac_sec_ded`

## Requirements
- R1: In mode `00`, `chk_out` bit k equals the XOR of `data_in & M[k]` with bits 0 and 1 then inverted. The group masks are M[0]=0x271B, M[1]=0x496D, M[2]=0x92B6, M[3]=0x1CC7, M[4]=0xE0F8 and M[5]=0xFF00. In this mode both flags are low and `data_out` is zero.
- R2: In modes `00` and `01` both flags are low. In modes `01` and `11` `chk_out` is zero, and `data_out` is zero in every mode except `10`. This includes the first cycle after reset.
- R3: The unit captures `data_in` and `chk_in` only at a clock edge where `mode[1]` is 1 and was 0 at the previous edge. The captured word drives the outputs from the next cycle on. A move from `10` to `11` does not capture.
- R4: In mode `10`, syndrome bit k on `chk_out` is 1 when stored check bit k equals the check bit recomputed from the stored data. For example, an error in data bit 0 gives zeros in bits 0, 1 and 3 (0b110100). An error in data bit 15 gives 0b001011, and an error in check bit 0 gives 0b111110.
- R5: With no error the syndrome is all ones, both flags are low and `data_out` equals the stored data.
- R6: A single data-bit error raises only `single_err`, and `data_out` returns the stored data with that bit inverted back.
- R7: A single check-bit error raises only `single_err`, and the data passes unchanged.
- R8: Any two-bit error in the 22-bit word raises both flags, and the data passes uncorrected.
- R9: A syndrome with three zeros that matches no data bit's column, or with five zeros, raises both flags and makes no correction.
- R10: A stored word that is all zeros, or all ones, raises both flags.
- R11: In modes `11` and `10` the flags and the syndrome depend only on the captured word. They stay fixed while the inputs change, until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Function select: 00 generate, 01 pass, 11 latch and flag, 10 correct |
| data_in | input | 16 | Data word from the processor or from memory |
| chk_in | input | 6 | Check word read from memory |
| data_out | output | 16 | Corrected data in mode 10, zero otherwise |
| chk_out | output | 6 | Generated check word in mode 00, syndrome in mode 10 |
| single_err | output | 1 | An error was found in the captured word |
| double_err | output | 1 | The error found cannot be corrected |

## Verification
The hardest cases to reach are the three-zero syndromes that no data column uses. No one-bit or two-bit fault produces them, so random memory faults almost never reach them. The stimulus writes a clean code word and then flips exactly the check-bit triples that form the four unused columns, plus one five-bit pattern. The test for capturing only on an edge is also hard to reach. It needs a `10` to `11` move with a different word on the bus, and a following correct cycle that must still return the old word.

// File: rtl/edac_pkg.sv
package edac_pkg;

   localparam int unsigned DATA_W = 16;
   localparam int unsigned CHK_W  = 6;

   // parity groups: element k lists the data bits that feed check bit k
   localparam logic [CHK_W-1:0][DATA_W-1:0] GROUP_MASK = {
      16'hFF00, 16'hE0F8, 16'h1CC7, 16'h92B6, 16'h496D, 16'h271B
   };

   // check bits stored in complemented form
   localparam logic [CHK_W-1:0] CHK_INVERT = 6'b000011;

   typedef enum logic [1:0] {
      MODE_GEN   = 2'b00,
      MODE_PASS  = 2'b01,
      MODE_CORR  = 2'b10,
      MODE_LATCH = 2'b11
   } mode_e;

endpackage

// File: rtl/edac_parity_gen.sv
module edac_parity_gen #(
   parameter int unsigned DATA_W = edac_pkg::DATA_W,
   parameter int unsigned CHK_W  = edac_pkg::CHK_W,
   parameter int unsigned COVER  = 3,
   parameter logic [CHK_W-1:0][DATA_W-1:0] GROUP_MASK = edac_pkg::GROUP_MASK,
   parameter logic [CHK_W-1:0] CHK_INVERT = edac_pkg::CHK_INVERT
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   localparam int unsigned ROW_W = DATA_W * COVER / CHK_W;

   function automatic int unsigned col_weight(input int unsigned col);
      int unsigned n = 0;
      for (int unsigned k = 0; k < CHK_W; k++) n += int'(GROUP_MASK[k][col]);
      return n;
   endfunction

   function automatic int unsigned row_weight(input int unsigned row);
      int unsigned n = 0;
      for (int unsigned i = 0; i < DATA_W; i++) n += int'(GROUP_MASK[row][i]);
      return n;
   endfunction

   for (genvar i = 0; i < DATA_W; i++) begin : g_col_chk
      if (col_weight(i) != COVER) begin : g_bad
         $error("data bit %0d is not in exactly %0d groups", i, COVER);
      end
   end

   for (genvar g = 0; g < CHK_W; g++) begin : g_tree
      if (row_weight(g) != ROW_W) begin : g_bad
         $error("group %0d does not hold %0d data bits", g, ROW_W);
      end
      assign chk[g] = (^(data & GROUP_MASK[g])) ^ CHK_INVERT[g];
   end

endmodule

// File: rtl/edac_syndrome_decode.sv
module edac_syndrome_decode #(
   parameter int unsigned DATA_W = edac_pkg::DATA_W,
   parameter int unsigned CHK_W  = edac_pkg::CHK_W,
   parameter logic [CHK_W-1:0][DATA_W-1:0] GROUP_MASK = edac_pkg::GROUP_MASK
) (
   input  logic [CHK_W-1:0]  syndrome,
   output logic [DATA_W-1:0] flip,
   output logic              single_err,
   output logic              double_err
);

   localparam int unsigned CNT_W = $clog2(CHK_W + 1);

   function automatic logic [CHK_W-1:0] column_of(input int unsigned col);
      logic [CHK_W-1:0] c;
      for (int unsigned k = 0; k < CHK_W; k++) c[k] = GROUP_MASK[k][col];
      return c;
   endfunction

   logic [CHK_W-1:0] bad_pos;
   logic [CNT_W-1:0] bad_cnt;
   logic             col_hit;

   assign bad_pos = ~syndrome;

   for (genvar i = 0; i < DATA_W; i++) begin : g_match
      localparam logic [CHK_W-1:0] COL = column_of(i);
      assign flip[i] = (bad_pos == COL);
   end

   assign col_hit = |flip;

   always_comb begin
      bad_cnt = '0;
      for (int unsigned k = 0; k < CHK_W; k++) bad_cnt += CNT_W'(bad_pos[k]);
   end

   assign single_err = |bad_pos;
   assign double_err = (|bad_pos) && !(col_hit || bad_cnt == CNT_W'(1));

endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded #(
   parameter int unsigned DATA_W = edac_pkg::DATA_W,
   parameter int unsigned CHK_W  = edac_pkg::CHK_W,
   parameter logic [CHK_W-1:0][DATA_W-1:0] GROUP_MASK = edac_pkg::GROUP_MASK,
   parameter logic [CHK_W-1:0] CHK_INVERT = edac_pkg::CHK_INVERT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [DATA_W-1:0] data_out,
   output logic [CHK_W-1:0]  chk_out,
   output logic              single_err,
   output logic              double_err
);
   import edac_pkg::*;

   if (DATA_W < 2 || CHK_W < 3) begin : g_bad_size
      $error("code too small for single-error correction");
   end

   logic              s1_q;
   logic              capture;
   logic [DATA_W-1:0] lat_data;
   logic [CHK_W-1:0]  lat_chk;
   logic [CHK_W-1:0]  gen_chk;
   logic [CHK_W-1:0]  re_chk;
   logic [CHK_W-1:0]  syndrome;
   logic [DATA_W-1:0] flip;
   logic              dec_single;
   logic              dec_double;

   assign capture = mode[1] && !s1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q     <= 1'b0;
         lat_data <= '0;
         lat_chk  <= '0;
      end else begin
         s1_q <= mode[1];
         if (capture) begin
            lat_data <= data_in;
            lat_chk  <= chk_in;
         end
      end
   end

   edac_parity_gen #(
      .DATA_W(DATA_W), .CHK_W(CHK_W),
      .GROUP_MASK(GROUP_MASK), .CHK_INVERT(CHK_INVERT)
   ) i_gen_write (
      .data(data_in),
      .chk (gen_chk)
   );

   edac_parity_gen #(
      .DATA_W(DATA_W), .CHK_W(CHK_W),
      .GROUP_MASK(GROUP_MASK), .CHK_INVERT(CHK_INVERT)
   ) i_gen_read (
      .data(lat_data),
      .chk (re_chk)
   );

   assign syndrome = ~(lat_chk ^ re_chk);

   edac_syndrome_decode #(
      .DATA_W(DATA_W), .CHK_W(CHK_W), .GROUP_MASK(GROUP_MASK)
   ) i_decode (
      .syndrome  (syndrome),
      .flip      (flip),
      .single_err(dec_single),
      .double_err(dec_double)
   );

   always_comb begin
      data_out   = '0;
      chk_out    = '0;
      single_err = 1'b0;
      double_err = 1'b0;
      case (mode)
         MODE_GEN:   chk_out = gen_chk;
         MODE_LATCH: begin
            single_err = dec_single;
            double_err = dec_double;
         end
         MODE_CORR: begin
            data_out   = lat_data ^ flip;
            chk_out    = syndrome;
            single_err = dec_single;
            double_err = dec_double;
         end
         default: ;
      endcase
   end

   // capture only on a rising mode[1]
   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (lat_data == $past(data_in)) && (lat_chk == $past(chk_in)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(lat_data) && $stable(lat_chk));

   // no error: clean pass-through
   assert_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && chk_out == '1) |-> (!single_err && data_out == lat_data));

   // a corrected data error changes one bit at most
   assert_one_fix_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && single_err && !double_err)
         |-> ($countones(data_out ^ lat_data) <= 1));

   // a check-bit error leaves the data alone
   assert_chk_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && $countones(~chk_out) == 1)
         |-> (data_out == lat_data && single_err && !double_err));

   // an uncorrectable error raises both flags and keeps the data
   assert_double_R8: assert property (@(posedge clk) disable iff (!rst_n)
      double_err |-> single_err);
   assert_no_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && double_err) |-> (data_out == lat_data));

   // three zeros with no correction means an unused column
   assert_unused_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && $countones(~chk_out) == 3 && data_out == lat_data)
         |-> double_err);

   // syndrome steady until the next capture
   assert_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CORR && s1_q) |=> (mode != MODE_CORR) || $stable(chk_out));

endmodule

// File: tb/test_edac_sec_ded.sv
`timescale 1ns/1ps
module test_edac_sec_ded;

   typedef struct {
      bit          valid;
      logic [15:0] d;
      logic [5:0]  c;
      logic        se;
      logic        de;
      string       req;
   } exp_t;

   localparam logic [15:0] MASK [6] = '{16'h271B, 16'h496D, 16'h92B6,
                                        16'h1CC7, 16'hE0F8, 16'hFF00};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b01;
   logic [15:0] data_in = '0;
   logic [5:0]  chk_in = '0;
   logic [15:0] data_out;
   logic [5:0]  chk_out;
   logic        single_err;
   logic        double_err;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   exp_t q[$];
   exp_t cur;

   always #2.5 clk = ~clk;

   edac_sec_ded i_edac_sec_ded (
      .clk(clk), .rst_n(rst_n), .mode(mode), .data_in(data_in), .chk_in(chk_in),
      .data_out(data_out), .chk_out(chk_out),
      .single_err(single_err), .double_err(double_err)
   );

   function automatic logic [5:0] genc(input logic [15:0] d);
      logic [5:0] r;
      for (int k = 0; k < 6; k++) r[k] = ^(d & MASK[k]);
      return r ^ 6'b000011;
   endfunction

   function automatic logic [5:0] synd(input logic [15:0] d, input logic [5:0] c);
      return ~(c ^ genc(d));
   endfunction

   function automatic exp_t mk(input bit v, input logic [15:0] d, input logic [5:0] c,
                               input logic se, input logic de, input string req);
      exp_t e;
      e.valid = v; e.d = d; e.c = c; e.se = se; e.de = de; e.req = req;
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: one scoreboard entry per cycle, compared mid-cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         cur = q.pop_front();
         if (cur.valid) begin
            check(data_out === cur.d, cur.req, "data_out", 32'(data_out), 32'(cur.d));
            check(chk_out === cur.c, cur.req, "chk_out", 32'(chk_out), 32'(cur.c));
            check(single_err === cur.se, cur.req, "single_err", 32'(single_err), 32'(cur.se));
            check(double_err === cur.de, cur.req, "double_err", 32'(double_err), 32'(cur.de));
         end
      end
   end

   task automatic step(input logic [1:0] m, input logic [15:0] d, input logic [5:0] c,
                       input exp_t e);
      @(posedge clk);
      #1;
      mode = m; data_in = d; chk_in = c;
      q.push_back(e);
   endtask

   // full read: pass, latch (capture), latch with bus scrambled, correct
   task automatic read_word(input logic [15:0] ds, input logic [5:0] cs,
                            input logic [15:0] ed, input logic [5:0] es,
                            input logic ese, input logic ede, input string req);
      step(2'b01, ds, cs, mk(1, '0, '0, 0, 0, "R2"));
      step(2'b11, ds, cs, mk(0, '0, '0, 0, 0, ""));
      step(2'b11, ~ds, ~cs, mk(1, '0, '0, ese, ede, req));
      step(2'b10, ds ^ 16'h5A5A, cs ^ 6'h15, mk(1, ed, es, ese, ede, req));
   endtask

   initial begin
      logic [15:0] words [8] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234,
                                 16'h8001, 16'h7FFE, 16'h0F0F, 16'hC33C};
      logic [5:0]  pats [5]  = '{6'b000111, 6'b011001, 6'b100110, 6'b111000, 6'b011111};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state (R2)
      step(2'b01, 16'h1357, 6'h2A, mk(1, '0, '0, 0, 0, "R2"));

      // check word generation (R1)
      foreach (words[i])
         step(2'b00, words[i], 6'h3F, mk(1, '0, genc(words[i]), 0, 0, "R1"));

      // documented syndrome codes (R4)
      read_word(16'hA5A5 ^ 16'h0001, genc(16'hA5A5), 16'hA5A5, 6'b110100, 1, 0, "R4");
      read_word(16'hA5A5 ^ 16'h8000, genc(16'hA5A5), 16'hA5A5, 6'b001011, 1, 0, "R4");
      read_word(16'hA5A5, genc(16'hA5A5) ^ 6'h01, 16'hA5A5, 6'b111110, 1, 0, "R4");

      foreach (words[w]) begin
         logic [15:0] d;
         logic [5:0]  c;
         d = words[w];
         c = genc(d);
         read_word(d, c, d, 6'h3F, 0, 0, "R5");
         for (int i = 0; i < 16; i++)
            read_word(d ^ (16'h1 << i), c, d, synd(d ^ (16'h1 << i), c), 1, 0, "R6");
         for (int k = 0; k < 6; k++)
            read_word(d, c ^ (6'h1 << k), d, synd(d, c ^ (6'h1 << k)), 1, 0, "R7");
         for (int j = 0; j < 22; j++) begin
            logic [21:0] v;
            v = {c, d} ^ (22'h1 << j) ^ (22'h1 << ((j + 5) % 22));
            read_word(v[15:0], v[21:16], v[15:0], synd(v[15:0], v[21:16]), 1, 1, "R8");
         end
      end

      // unused columns and five-zero syndrome (R9)
      foreach (pats[p])
         read_word(16'h1234, genc(16'h1234) ^ pats[p], 16'h1234,
                   ~pats[p], 1, 1, "R9");

      // stuck words (R10)
      read_word(16'h0000, 6'h00, 16'h0000, synd(16'h0000, 6'h00), 1, 1, "R10");
      read_word(16'hFFFF, 6'h3F, 16'hFFFF, synd(16'hFFFF, 6'h3F), 1, 1, "R10");

      // 10 -> 11 must not capture the new bus word (R3), flags steady (R11)
      read_word(16'h4C2D, genc(16'h4C2D), 16'h4C2D, 6'h3F, 0, 0, "R11");
      step(2'b11, 16'hFFFF, 6'h00, mk(1, '0, '0, 0, 0, "R3"));
      step(2'b10, 16'hFFFF, 6'h00, mk(1, 16'h4C2D, 6'h3F, 0, 0, "R3"));
      step(2'b10, 16'h0001, 6'h3F, mk(1, 16'h4C2D, 6'h3F, 0, 0, "R11"));

      step(2'b01, '0, '0, mk(1, '0, '0, 0, 0, "R2"));
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
         $finish;
      end
   end

endmodule